// File: doc/BRIEF.md
# State-Enable Access Gate

This block decides whether a hart may use a resource that the state-enable scheme guards, and whether it may access the hypervisor-level or supervisor-level state-enable registers themselves. Each request carries the current privilege, the virtualization flag, the extension and mode presence flags, a debugger flag, and the machine, hypervisor and supervisor state-enable words for the selected index. A resource request also carries the index of the enable bit under test. The block returns one of three outcomes: access allowed, illegal-instruction, or virtual-instruction fault. It holds no state-enable storage. The surrounding CSR file supplies the words.

A request is a one-cycle pulse on `in_vld` with its operands. With the default output register, the verdict appears on `res` one clock later, qualified by `out_vld`. The block accepts a request on every cycle and never stalls, so it has no ready signal and no back-pressure. With `REG_OUT` set to 0 the verdict is combinational.

Checks follow a fixed order. For resource requests the machine level is checked first, then the hypervisor level, then the supervisor level. For register requests the order is extension presence, then mode presence, then the debugger bypass, then the machine-level control bit.

Top module: `seg_gate`

## Requirements
- R1: `res` uses 2'b00 for allowed, 2'b01 for illegal-instruction and 2'b10 for virtual-instruction fault, and is never 2'b11. With `REG_OUT`=1 each request pulse gives exactly one `out_vld` pulse one clock later. Reset clears `out_vld` and `res` to 0.
- R2: A resource request (`op`=2'b00) is allowed when `priv`=2'b11 (machine) or `ext_on`=0. Any other `priv` code counts as below machine, with 2'b00 meaning user and 2'b01 meaning supervisor.
- R3: For a resource request below machine with the extension present, a clear bit `bit_sel` of `m_word` gives illegal-instruction. This overrides every other level, including a clear hypervisor bit under virtualization.
- R4: For a resource request with `virt`=1 and the machine bit set, a clear bit `bit_sel` of `h_word` gives virtual-instruction fault.
- R5: With `virt`=1 in user mode, a clear supervisor bit gives virtual-instruction fault. With `virt`=1 in supervisor mode, the supervisor bit has no effect.
- R6: With `virt`=0 in user mode, a clear supervisor bit gives illegal-instruction when `smode_on`=1 and is ignored when `smode_on`=0.
- R7: A register request (`op`=2'b01 hypervisor-level, `op`=2'b10 supervisor-level) with `ext_on`=0 gives illegal-instruction, even when `dbg`=1.
- R8: A hypervisor-level register request with `hmode_on`=0, or a supervisor-level one with `smode_on`=0, gives illegal-instruction. This check comes before the debugger bypass.
- R9: Once the mode check passes, a register request with `dbg`=1 is allowed whatever the enable words hold.
- R10: A register request without debugger access below machine mode is illegal-instruction when bit `WORD_W-1` of `m_word` is clear. It is allowed when that bit is set, and always allowed in machine mode.
- R11: For resource requests only bit `bit_sel` of each word matters. All other bits have no effect.
- R12: `op`=2'b11 is reserved and always gives illegal-instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Request pulse |
| op | input | 2 | Request kind: resource, hypervisor register, supervisor register, reserved |
| priv | input | 2 | Current privilege: 2'b11 M, 2'b01 S, 2'b00 U |
| virt | input | 1 | Virtualization active |
| ext_on | input | 1 | State-enable extension present |
| smode_on | input | 1 | Supervisor mode implemented |
| hmode_on | input | 1 | Hypervisor mode implemented |
| dbg | input | 1 | Access comes from the debugger |
| m_word | input | WORD_W | Machine-level enable word |
| h_word | input | WORD_W | Hypervisor-level enable word |
| s_word | input | WORD_W | Supervisor-level enable word |
| bit_sel | input | $clog2(WORD_W) | Index of the enable bit under test |
| out_vld | output | 1 | Verdict valid |
| res | output | 2 | Verdict code |

## Verification
On every cycle, the assertions check the legality of the verdict code and the one-to-one timing of `out_vld`. They also check that a virtual-instruction fault only follows a request made under virtualization. Further assertions cover the machine-mode grant, extension absence on register requests, the debugger bypass, and machine-bit denial. The precedence between levels can only be shown by the bench's scenarios. These include a clear machine bit beating a clear hypervisor bit, and the mode check beating the debugger. The same holds for the supervisor-bit cases that depend on the mode combination, and for the insensitivity to unselected bits.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    SEG_OK   = 2'b00,
    SEG_ILL  = 2'b01,
    SEG_VIRT = 2'b10
  } seg_res_e;

  typedef enum logic [1:0] {
    OP_RES  = 2'b00,
    OP_HREG = 2'b01,
    OP_SREG = 2'b10,
    OP_RSVD = 2'b11
  } seg_op_e;

  localparam logic [1:0] LVL_U = 2'b00;
  localparam logic [1:0] LVL_S = 2'b01;
  localparam logic [1:0] LVL_M = 2'b11;

  localparam int NUM_LVL = 3;
endpackage

// File: rtl/seg_bit_pick.sv
module seg_bit_pick #(
  parameter int WORD_W = 64,
  localparam int SEL_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic              bit_o
);
  always_comb bit_o = word[sel];
endmodule

// File: rtl/seg_res_chk.sv
module seg_res_chk
  import seg_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       ext_on,
  input  logic       smode_on,
  input  logic       m_bit,
  input  logic       h_bit,
  input  logic       s_bit,
  output seg_res_e   verdict
);
  logic is_user;
  always_comb is_user = (priv == LVL_U);

  always_comb begin
    verdict = SEG_OK;
    if (priv == LVL_M || !ext_on) begin
      verdict = SEG_OK;
    end else if (!m_bit) begin
      verdict = SEG_ILL;
    end else if (virt && !h_bit) begin
      verdict = SEG_VIRT;
    end else if (virt && is_user && !s_bit) begin
      verdict = SEG_VIRT;
    end else if (!virt && is_user && smode_on && !s_bit) begin
      verdict = SEG_ILL;
    end
  end
endmodule

// File: rtl/seg_reg_chk.sv
module seg_reg_chk
  import seg_pkg::*;
(
  input  logic [1:0] op,
  input  logic [1:0] priv,
  input  logic       ext_on,
  input  logic       hmode_on,
  input  logic       smode_on,
  input  logic       dbg,
  input  logic       m_ctl,
  output seg_res_e   verdict
);
  logic mode_ok;
  always_comb mode_ok = (op == OP_HREG) ? hmode_on : smode_on;

  always_comb begin
    verdict = SEG_OK;
    if (!ext_on) begin
      verdict = SEG_ILL;
    end else if (!mode_ok) begin
      verdict = SEG_ILL;
    end else if (dbg) begin
      verdict = SEG_OK;
    end else if (priv != LVL_M && !m_ctl) begin
      verdict = SEG_ILL;
    end
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld_i,
  input  logic [1:0] res_i,
  output logic       vld_o,
  output logic [1:0] res_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_o <= 1'b0;
          res_o <= 2'b00;
        end else begin
          vld_o <= vld_i;
          res_o <= vld_i ? res_i : 2'b00;
        end
      end
    end else begin : g_comb
      always_comb begin
        vld_o = vld_i;
        res_o = vld_i ? res_i : 2'b00;
      end
    end
  endgenerate
endmodule

// File: rtl/seg_gate.sv
module seg_gate
  import seg_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int SEL_W  = $clog2(WORD_W),
  localparam int CTL_BIT = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [1:0]        op,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              ext_on,
  input  logic              smode_on,
  input  logic              hmode_on,
  input  logic              dbg,
  input  logic [WORD_W-1:0] m_word,
  input  logic [WORD_W-1:0] h_word,
  input  logic [WORD_W-1:0] s_word,
  input  logic [SEL_W-1:0]  bit_sel,
  output logic              out_vld,
  output logic [1:0]        res
);
  logic [NUM_LVL-1:0][WORD_W-1:0] words;
  logic [NUM_LVL-1:0]             picked;
  seg_res_e                       res_verdict;
  seg_res_e                       reg_verdict;
  logic [1:0]                     verdict;

  always_comb words = {s_word, h_word, m_word};

  generate
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_pick
      seg_bit_pick #(.WORD_W(WORD_W)) u_pick (
        .word  (words[g]),
        .sel   (bit_sel),
        .bit_o (picked[g])
      );
    end
  endgenerate

  seg_res_chk u_res (
    .priv     (priv),
    .virt     (virt),
    .ext_on   (ext_on),
    .smode_on (smode_on),
    .m_bit    (picked[0]),
    .h_bit    (picked[1]),
    .s_bit    (picked[2]),
    .verdict  (res_verdict)
  );

  seg_reg_chk u_reg (
    .op       (op),
    .priv     (priv),
    .ext_on   (ext_on),
    .hmode_on (hmode_on),
    .smode_on (smode_on),
    .dbg      (dbg),
    .m_ctl    (m_word[CTL_BIT]),
    .verdict  (reg_verdict)
  );

  always_comb begin
    unique case (op)
      OP_RES:           verdict = res_verdict;
      OP_HREG, OP_SREG: verdict = reg_verdict;
      default:          verdict = SEG_ILL;
    endcase
  end

  seg_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_vld),
    .res_i (verdict),
    .vld_o (out_vld),
    .res_o (res)
  );
endmodule

// File: rtl/seg_gate_chk.sv
module seg_gate_chk #(
  parameter int WORD_W  = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int SEL_W  = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [1:0]        op,
  input logic [1:0]        priv,
  input logic              virt,
  input logic              ext_on,
  input logic              smode_on,
  input logic              hmode_on,
  input logic              dbg,
  input logic [WORD_W-1:0] m_word,
  input logic [WORD_W-1:0] h_word,
  input logic [WORD_W-1:0] s_word,
  input logic [SEL_W-1:0]  bit_sel,
  input logic              out_vld,
  input logic [1:0]        res
);
  // R1
  enc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res != 2'b11);

  generate
    if (REG_OUT) begin : g_seq
      // R1
      vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
      // R1
      vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
      // R4
      virt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && !virt |=> res != 2'b10);
      // R2
      mach_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && op == 2'b00 && priv == 2'b11 |=> res == 2'b00);
      // R3
      mbit_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && op == 2'b00 && priv != 2'b11 && ext_on && !m_word[bit_sel]
        |=> res == 2'b01);
      // R7
      reg_noext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && (op == 2'b01 || op == 2'b10) && !ext_on |=> res == 2'b01);
      // R9
      dbg_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && ext_on && dbg &&
        ((op == 2'b01 && hmode_on) || (op == 2'b10 && smode_on))
        |=> res == 2'b00);
      // R12
      rsvd_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && op == 2'b11 |=> res == 2'b01);
    end
  endgenerate
endmodule

bind seg_gate seg_gate_chk #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .priv(priv),
  .virt(virt), .ext_on(ext_on), .smode_on(smode_on), .hmode_on(hmode_on),
  .dbg(dbg), .m_word(m_word), .h_word(h_word), .s_word(s_word),
  .bit_sel(bit_sel), .out_vld(out_vld), .res(res)
);

// File: tb/tb_seg_gate.sv
module tb_seg_gate;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [1:0] op = '0, priv = '0;
  logic virt = 0, ext_on = 0, smode_on = 0, hmode_on = 0, dbg = 0;
  logic [W-1:0] m_word = '0, h_word = '0, s_word = '0;
  logic [5:0] bit_sel = '0;
  logic out_vld;
  logic [1:0] res;

  int total = 0;
  int bad = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  seg_gate dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .priv(priv),
    .virt(virt), .ext_on(ext_on), .smode_on(smode_on), .hmode_on(hmode_on),
    .dbg(dbg), .m_word(m_word), .h_word(h_word), .s_word(s_word),
    .bit_sel(bit_sel), .out_vld(out_vld), .res(res)
  );

  function automatic logic [1:0] model(
    input logic [1:0] o, input logic [1:0] pv, input logic vt, ex, sm, hm, db,
    input logic [W-1:0] mw, hw, sw, input int sel);
    if (o == 2'b11) return 2'b01;
    if (o == 2'b00) begin
      if (pv == 2'b11 || !ex) return 2'b00;
      if (!mw[sel]) return 2'b01;
      if (vt && !hw[sel]) return 2'b10;
      if (vt && pv == 2'b00 && !sw[sel]) return 2'b10;
      if (!vt && pv == 2'b00 && sm && !sw[sel]) return 2'b01;
      return 2'b00;
    end
    if (!ex) return 2'b01;
    if (o == 2'b01 && !hm) return 2'b01;
    if (o == 2'b10 && !sm) return 2'b01;
    if (db) return 2'b00;
    if (pv != 2'b11 && !mw[W-1]) return 2'b01;
    return 2'b00;
  endfunction

  task automatic send(input logic [1:0] o, input logic [1:0] pv,
    input logic vt, ex, sm, hm, db, input logic [W-1:0] mw, hw, sw,
    input int sel, input string tag);
    @(negedge clk);
    op = o; priv = pv; virt = vt; ext_on = ex; smode_on = sm; hmode_on = hm;
    dbg = db; m_word = mw; h_word = hw; s_word = sw; bit_sel = 6'(sel);
    in_vld = 1'b1;
    exp_q.push_back(model(o, pv, vt, ex, sm, hm, db, mw, hw, sw, sel));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected out_vld: actual res=%b expected none", res);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (res !== e) begin
          bad++;
          $display("FAIL %s actual=%b expected=%b", t, res, e);
        end
      end
    end
  end

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ZERO = '0;

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_vld !== 1'b0 || res !== 2'b00) begin
      bad++;
      $display("FAIL R1 reset state actual vld=%b res=%b expected vld=0 res=00", out_vld, res);
    end
    rst_n = 1'b1;
    // R2 machine mode and absent extension
    send(2'b00, 2'b11, 0, 1, 1, 1, 0, ZERO, ZERO, ZERO, 3, "R2 machine grant");
    send(2'b00, 2'b00, 1, 0, 1, 1, 0, ZERO, ZERO, ZERO, 3, "R2 ext absent");
    // R3 machine bit beats virtualization
    send(2'b00, 2'b01, 1, 1, 1, 1, 0, ZERO, ZERO, ONES, 7, "R3 mbit over hbit");
    send(2'b00, 2'b00, 0, 1, 1, 1, 0, ~(ONES & 64'(1 << 7)), ONES, ONES, 7, "R3 mbit user");
    // R4
    send(2'b00, 2'b01, 1, 1, 1, 1, 0, ONES, ZERO, ONES, 12, "R4 hbit virt");
    send(2'b00, 2'b01, 0, 1, 1, 1, 0, ONES, ZERO, ONES, 12, "R4 hbit no virt");
    // R5
    send(2'b00, 2'b00, 1, 1, 1, 1, 0, ONES, ONES, ZERO, 20, "R5 virt user sbit");
    send(2'b00, 2'b01, 1, 1, 1, 1, 0, ONES, ONES, ZERO, 20, "R5 virt sup sbit ignored");
    // R6
    send(2'b00, 2'b00, 0, 1, 1, 0, 0, ONES, ZERO, ZERO, 40, "R6 user with smode");
    send(2'b00, 2'b00, 0, 1, 0, 0, 0, ONES, ZERO, ZERO, 40, "R6 user no smode");
    // R11 only selected bit matters
    send(2'b00, 2'b00, 1, 1, 1, 1, 0, 64'h1 << 63, 64'h1 << 63, 64'h1 << 63, 63, "R11 top bit only set");
    send(2'b00, 2'b00, 1, 1, 1, 1, 0, ~64'h1, ~64'h1, ~64'h1, 0, "R11 bit0 only clear");
    send(2'b00, 2'b00, 1, 1, 1, 1, 0, ~64'h1, ONES, ONES, 1, "R11 neighbour set");
    // R7
    send(2'b01, 2'b01, 0, 0, 1, 1, 1, ONES, ONES, ONES, 0, "R7 hreg ext absent dbg");
    send(2'b10, 2'b11, 0, 0, 1, 1, 0, ONES, ONES, ONES, 0, "R7 sreg ext absent");
    // R8
    send(2'b01, 2'b11, 0, 1, 1, 0, 1, ONES, ONES, ONES, 0, "R8 no hmode beats dbg");
    send(2'b10, 2'b11, 0, 1, 0, 1, 1, ONES, ONES, ONES, 0, "R8 no smode beats dbg");
    // R9
    send(2'b01, 2'b00, 1, 1, 1, 1, 1, ZERO, ZERO, ZERO, 0, "R9 dbg hreg");
    send(2'b10, 2'b01, 0, 1, 1, 0, 1, ZERO, ZERO, ZERO, 0, "R9 dbg sreg");
    // R10
    send(2'b10, 2'b01, 0, 1, 1, 1, 0, ~(64'h1 << 63), ONES, ONES, 0, "R10 ctl clear");
    send(2'b01, 2'b01, 1, 1, 1, 1, 0, 64'h1 << 63, ZERO, ZERO, 0, "R10 ctl set");
    send(2'b01, 2'b11, 0, 1, 1, 1, 0, ZERO, ZERO, ZERO, 0, "R10 machine");
    // R12
    send(2'b11, 2'b11, 0, 1, 1, 1, 1, ONES, ONES, ONES, 0, "R12 reserved op");
    idle(4);
    // R1 spaced requests
    send(2'b00, 2'b00, 0, 1, 1, 1, 0, ONES, ONES, ONES, 9, "R1 isolated pulse");
    idle(4);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1 missing verdicts actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule